// File: doc/BRIEF.md
# Serial Boundary-Scan Test Port

This block is the serial test port of a memory device. A sixteen-state controller steps on the rising edge of the test clock, under the mode-select input. It routes the serial data input through one scan register at a time and out on the serial data output. That register is either the 3-bit instruction register or the data register that the current instruction picks. The data registers are a 1-bit bypass stage, a 32-bit identification register and a boundary register whose length is a parameter.

The boundary register takes a parallel snapshot from `bnd_capture_i`. It presents its shifted contents on `bnd_update_o`. The surrounding pad logic decides what to do with them.

The serial output is launched on the falling edge. It is driven only while a shift state is active and floats at every other time. Power-up, or holding mode-select high for five clocks, returns the port to its reset state with the identification instruction loaded.

Top module: `scan_port`

## Requirements
- R1: While `rst_ni` is low, the controller is in its reset state and the instruction is IDCODE (3'b001). In that state `tdo_en_o` is 0, `tdo_o` is high-Z and `bnd_update_o` is all zeros.
- R2: Five consecutive rising `tck_i` edges with `tms_i` high bring the controller to the reset state from any state. In the reset state the instruction reloads IDCODE on the falling edge.
- R3: `tms_i` and `tdi_i` are sampled only on rising `tck_i`. `tdo_o` and `tdo_en_o` change only on falling `tck_i`.
- R4: State moves follow the standard sixteen-state diagram, including the pause loops (Exit1→Pause on 0, Pause→Exit2 on 1, Exit2→Shift on 0) and the Select-IR→Reset move on 1.
- R5: The instruction register is 3 bits. Capture-IR loads 3'b001 into it. Shift-IR moves `tdi_i` into bit 2 and sends bit 0 out first. The new instruction takes effect on the falling edge in Update-IR and not before.
- R6: The instruction codes are 3'b000 EXTEST (boundary), 3'b001 IDCODE (identification), 3'b100 SAMPLE/PRELOAD (boundary) and 3'b111 BYPASS. Every other code selects the bypass register.
- R7: The bypass register captures 0 and gives a one-clock delay from `tdi_i` to `tdo_o`.
- R8: The identification register captures the 32-bit `ID_VALUE`, whose bit 0 is 1. It is shifted out LSB first.
- R9: Under EXTEST or SAMPLE/PRELOAD, Capture-DR loads `bnd_capture_i`. A scan of `BND_LEN` bits returns it LSB first, and `tdi_i` enters the MSB.
- R10: On the falling edge in Update-DR, `bnd_update_o` takes the boundary shift contents, but only while a boundary instruction is active. Under the other instructions `bnd_update_o` is unchanged.
- R11: `tdo_en_o` is 1 exactly from the falling edge in Shift-IR or Shift-DR until the next falling edge in a non-shift state. While it is 0, `tdo_o` is high-Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| tms_i | input | 1 | Mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, high-Z when not shifting |
| tdo_en_o | output | 1 | Output enable of `tdo_o` |
| bnd_capture_i | input | BND_LEN | Parallel values captured into the boundary register |
| bnd_update_o | output | BND_LEN | Boundary contents latched in Update-DR |

## Verification
Each serial bit is sampled on the rising edge. The bit it exposes on `tdo_o` appears after the next falling edge, half a clock later. The bench therefore compares the model two time units after each falling edge. It also confirms at the rising edge that the output has not moved.

Instruction and `bnd_update_o` changes are due at the falling edge of the Update state, so they are first compared at that same point. Each scan result is assembled by reading `tdo_o` before every shifting rising edge. This makes the first bit out the captured bit 0.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PS_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PS_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BND} dr_sel_e;

  function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE: decode_op = DR_BND;
      OP_IDCODE:            decode_op = DR_ID;
      default:              decode_op = DR_BYP;
    endcase
  endfunction
endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET:  state_d = tms_i ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PS_DR;
      ST_PS_DR:  state_d = tms_i ? ST_EX2_DR : ST_PS_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms_i ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PS_IR;
      ST_PS_IR:  state_d = tms_i ? ST_EX2_IR : ST_PS_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // run of consecutive TMS-high samples, saturating at 5
  logic [2:0] hi_run_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)           hi_run_q <= '0;
    else if (!tms_i)       hi_run_q <= '0;
    else if (hi_run_q < 5) hi_run_q <= hi_run_q + 3'd1;
  end

  a_r2_five_high_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (hi_run_q == 3'd5) |-> (state_q == ST_RESET));
  a_r4_pause_to_exit2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_PS_DR && tms_i) |=> (state_q == ST_EX2_DR));
  a_r4_exit2_to_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_EX2_IR && !tms_i) |=> (state_q == ST_SH_IR));
endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] op_o,
  output logic            lsb_o
);
  logic [IR_W-1:0] sr_q, op_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   sr_q <= IR_CAPTURE_PAT;
    else if (state_i == ST_CAP_IR) sr_q <= IR_CAPTURE_PAT;
    else if (state_i == ST_SH_IR)  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
  end

  // instruction changes only on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   op_q <= OP_IDCODE;
    else if (state_i == ST_RESET)  op_q <= OP_IDCODE;
    else if (state_i == ST_UPD_IR) op_q <= sr_q;
  end

  assign op_o  = op_q;
  assign lsb_o = sr_q[0];

  a_r5_capture_pattern: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_IR) |=> (sr_q == IR_CAPTURE_PAT));
  a_r5_op_hold: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UPD_IR && state_i != ST_RESET) |=> $stable(op_q));
endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_pkg::*;
#(
  parameter int          BND_LEN  = 16,
  parameter logic [31:0] ID_VALUE = 32'h1A5C_E0B7
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  tap_state_e         state_i,
  input  dr_sel_e            sel_i,
  input  logic               tdi_i,
  input  logic [BND_LEN-1:0] bnd_capture_i,
  output logic [BND_LEN-1:0] bnd_update_o,
  output logic               lsb_o
);
  localparam int ID_W = 32;

  logic cap, shf;
  assign cap = (state_i == ST_CAP_DR);
  assign shf = (state_i == ST_SH_DR);

  // bypass stage
  logic byp_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   byp_q <= 1'b0;
    else if (sel_i == DR_BYP && cap) byp_q <= 1'b0;
    else if (sel_i == DR_BYP && shf) byp_q <= tdi_i;
  end

  // identification register
  logic [ID_W-1:0] id_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                    id_q <= ID_VALUE;
    else if (sel_i == DR_ID && cap) id_q <= ID_VALUE;
    else if (sel_i == DR_ID && shf) id_q <= {tdi_i, id_q[ID_W-1:1]};
  end

  // boundary cells: shift stage plus falling-edge update latch
  logic [BND_LEN-1:0] bnd_sr_q, bnd_up_q;
  logic [BND_LEN:0]   chain;
  logic               bnd_sel;
  assign chain   = {tdi_i, bnd_sr_q};
  assign bnd_sel = (sel_i == DR_BND);

  for (genvar g = 0; g < BND_LEN; g++) begin : g_cell
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)              bnd_sr_q[g] <= 1'b0;
      else if (bnd_sel && cap)  bnd_sr_q[g] <= bnd_capture_i[g];
      else if (bnd_sel && shf)  bnd_sr_q[g] <= chain[g+1];
    end
    always_ff @(negedge tck_i or negedge rst_ni) begin
      if (!rst_ni)                                  bnd_up_q[g] <= 1'b0;
      else if (bnd_sel && state_i == ST_UPD_DR)     bnd_up_q[g] <= bnd_sr_q[g];
    end
  end

  assign bnd_update_o = bnd_up_q;

  always_comb begin
    case (sel_i)
      DR_ID:   lsb_o = id_q[0];
      DR_BND:  lsb_o = bnd_sr_q[0];
      default: lsb_o = byp_q;
    endcase
  end

  a_r7_bypass_zero: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap && sel_i == DR_BYP) |=> (byp_q == 1'b0));
  a_r8_id_capture: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (cap && sel_i == DR_ID) |=> (id_q[0] == 1'b1));
  a_r10_update_hold: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !(bnd_sel && state_i == ST_UPD_DR) |=> $stable(bnd_up_q));
endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_pkg::*;
#(
  parameter int          BND_LEN  = 16,
  parameter logic [31:0] ID_VALUE = 32'h1A5C_E0B7
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic               tdo_en_o,
  input  logic [BND_LEN-1:0] bnd_capture_i,
  output logic [BND_LEN-1:0] bnd_update_o
);
  tap_state_e      state;
  logic [IR_W-1:0] op;
  logic            ir_lsb, dr_lsb;
  dr_sel_e         sel;

  scan_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  scan_ir u_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .tdi_i   (tdi_i),
    .op_o    (op),
    .lsb_o   (ir_lsb)
  );

  assign sel = decode_op(op);

  scan_dr #(.BND_LEN(BND_LEN), .ID_VALUE(ID_VALUE)) u_dr (
    .tck_i         (tck_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .sel_i         (sel),
    .tdi_i         (tdi_i),
    .bnd_capture_i (bnd_capture_i),
    .bnd_update_o  (bnd_update_o),
    .lsb_o         (dr_lsb)
  );

  logic tdo_q, en_q;
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR)      tdo_q <= ir_lsb;
      else if (state == ST_SH_DR) tdo_q <= dr_lsb;
    end
  end

  assign tdo_o    = en_q ? tdo_q : 1'bz;
  assign tdo_en_o = en_q;

  a_r11_en_tracks_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == ((state == ST_SH_IR) || (state == ST_SH_DR)));
  a_r6_bnd_sel: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (op == OP_SAMPLE || op == OP_EXTEST) |-> (sel == DR_BND));
endmodule

// File: tb/sim_scan_port.sv
module sim_scan_port;
  localparam int          BL  = 16;
  localparam logic [31:0] IDV = 32'h1A5C_E0B7;

  localparam int S_TLR = 0, S_RTI = 1, S_SDS = 2, S_CDR = 3, S_SDR = 4, S_E1D = 5,
                 S_PDR = 6, S_E2D = 7, S_UDR = 8, S_SIS = 9, S_CIR = 10, S_SIR = 11,
                 S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

  logic tck = 0, rst_ni = 0, tms_i = 1, tdi_i = 0;
  logic tdo_o, tdo_en_o;
  logic [BL-1:0] bnd_capture_i = '0, bnd_update_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  scan_port #(.BND_LEN(BL), .ID_VALUE(IDV)) u0 (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .tdo_o(tdo_o), .tdo_en_o(tdo_en_o),
    .bnd_capture_i(bnd_capture_i), .bnd_update_o(bnd_update_o)
  );

  always #10 tck = ~tck;

  // behavioural reference
  int ms;
  logic [2:0] m_irs, m_ir;
  logic m_byp, m_en, m_tdo;
  logic [31:0] m_id;
  logic [BL-1:0] m_bnd, m_upd;

  function automatic int msel(input logic [2:0] c);
    if (c == 3'b000 || c == 3'b100) return 2;
    if (c == 3'b001) return 1;
    return 0;
  endfunction

  function automatic int nxt(input int s, input logic t);
    case (s)
      S_TLR: return t ? S_TLR : S_RTI;
      S_RTI: return t ? S_SDS : S_RTI;
      S_SDS: return t ? S_SIS : S_CDR;
      S_CDR, S_SDR: return t ? S_E1D : S_SDR;
      S_E1D: return t ? S_UDR : S_PDR;
      S_PDR: return t ? S_E2D : S_PDR;
      S_E2D: return t ? S_UDR : S_SDR;
      S_SIS: return t ? S_TLR : S_CIR;
      S_CIR, S_SIR: return t ? S_E1I : S_SIR;
      S_E1I: return t ? S_UIR : S_PIR;
      S_PIR: return t ? S_E2I : S_PIR;
      S_E2I: return t ? S_UIR : S_SIR;
      default: return t ? S_SDS : S_RTI; // both update states
    endcase
  endfunction

  task automatic m_reset();
    ms = S_TLR; m_irs = 3'b001; m_ir = 3'b001; m_byp = 0; m_en = 0; m_tdo = 0;
    m_id = IDV; m_bnd = '0; m_upd = '0;
  endtask

  task automatic m_rise(input logic t, input logic d);
    int k;
    k = msel(m_ir);
    if (ms == S_CIR) m_irs = 3'b001;
    else if (ms == S_SIR) m_irs = {d, m_irs[2:1]};
    else if (ms == S_CDR) begin
      if (k == 0) m_byp = 0; else if (k == 1) m_id = IDV; else m_bnd = bnd_capture_i;
    end else if (ms == S_SDR) begin
      if (k == 0) m_byp = d;
      else if (k == 1) m_id = {d, m_id[31:1]};
      else m_bnd = {d, m_bnd[BL-1:1]};
    end
    ms = nxt(ms, t);
  endtask

  task automatic m_fall();
    int k;
    if (ms == S_UIR) m_ir = m_irs;
    if (ms == S_TLR) m_ir = 3'b001;
    k = msel(m_ir);
    if (ms == S_UDR && k == 2) m_upd = m_bnd;
    m_en = (ms == S_SIR || ms == S_SDR);
    if (ms == S_SIR) m_tdo = m_irs[0];
    else if (ms == S_SDR) m_tdo = (k == 0) ? m_byp : (k == 1) ? m_id[0] : m_bnd[0];
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R11 tdo_en", {63'd0, tdo_en_o}, {63'd0, m_en});
    if (m_en) chk("R5/R7/R8/R9 tdo", {63'd0, tdo_o}, {63'd0, m_tdo});
    else      chk("R11 tdo_z", {63'd0, tdo_o}, {63'd0, 1'bz});
    chk("R10 upd", {{(64-BL){1'b0}}, bnd_update_o}, {{(64-BL){1'b0}}, m_upd});
  endtask

  // called at falling edge + 2
  task automatic tick(input logic t, input logic d);
    logic pt, pe;
    tms_i = t; tdi_i = d;
    pt = tdo_o; pe = tdo_en_o;
    @(posedge tck); #2;
    chk("R3 en_at_rise", {63'd0, tdo_en_o}, {63'd0, pe});
    chk("R3 tdo_at_rise", {63'd0, tdo_o}, {63'd0, pt});
    m_rise(t, d);
    @(negedge tck); #2;
    m_fall();
    cmp_all();
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo_o;
      tick(i == 2, op[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input bit pz,
                         output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo_o;
      tick((i == n - 1) || (pz && i == n / 2 - 1), din[i]);
      if (pz && i == n / 2 - 1) begin
        tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0); // pause, pause, exit2, shift
      end
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] c;
    logic [63:0] o;
    m_reset();
    repeat (3) @(negedge tck);
    #2;
    cmp_all(); // R1 reset outputs
    rst_ni = 1;
    tick(0, 0); // to idle

    // R8 / R1: default instruction is IDCODE
    scan_dr(32, 64'h0, 0, o);
    chk("R8 R1 idcode", o[31:0], IDV);

    // R5 capture pattern, R7 bypass delay
    load_ir(3'b111, c);
    chk("R5 ir_capture", {61'd0, c}, 64'd1);
    scan_dr(8, 64'hA5, 0, o);
    chk("R7 bypass", o[7:0], {8'hA5 << 1} & 8'hFF);

    // R6 unassigned code behaves as bypass
    load_ir(3'b010, c);
    scan_dr(8, 64'h3C, 0, o);
    chk("R6 unassigned_bypass", o[7:0], {8'h3C << 1} & 8'hFF);

    // R9 R10 R4 sample/preload with pause loop
    bnd_capture_i = 16'hC3A5;
    load_ir(3'b100, c);
    scan_dr(BL, 64'h5A0F, 1, o);
    chk("R9 sample_capture", o[BL-1:0], 16'hC3A5);
    chk("R10 sample_update", bnd_update_o, 16'h5A0F);

    // R10 unchanged under IDCODE
    load_ir(3'b001, c);
    scan_dr(32, 64'hFFFF_0000, 0, o);
    chk("R8 idcode_again", o[31:0], IDV);
    chk("R10 update_hold", bnd_update_o, 16'h5A0F);

    // R9 R6 extest
    bnd_capture_i = 16'h0FF1;
    load_ir(3'b000, c);
    scan_dr(BL, 64'h9669, 0, o);
    chk("R9 extest_capture", o[BL-1:0], 16'h0FF1);
    chk("R10 extest_update", bnd_update_o, 16'h9669);

    // R2 five TMS-high edges from Shift-DR
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R11 in_shift", {63'd0, tdo_en_o}, 64'd1);
    repeat (5) tick(1, 1);
    chk("R2 left_shift", {63'd0, tdo_en_o}, 64'd0);
    tick(0, 0);
    scan_dr(32, 64'h0, 0, o);
    chk("R2 idcode_reloaded", o[31:0], IDV);

    // R1 asynchronous reset mid-shift
    load_ir(3'b111, c);
    tick(1, 0); tick(0, 0); tick(0, 0);
    rst_ni = 0; #1;
    m_reset();
    chk("R1 async_en", {63'd0, tdo_en_o}, 64'd0);
    chk("R1 async_upd", bnd_update_o, 16'h0);
    @(negedge tck); #1; rst_ni = 1; #1;
    cmp_all();
    tick(0, 0);
    scan_dr(32, 64'h0, 0, o);
    chk("R1 idcode_after_reset", o[31:0], IDV);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule